// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a clocked host to an 8K x 8 asynchronous static RAM. The host raises a one-cycle request together with a read/write flag, a 13-bit word address and, for a write, a data byte. The controller then plays out the memory's pin sequence and answers with a one-cycle completion pulse. Read data waits in a host-side register when that pulse appears.

All memory pins come from registers. The write-enable pulse width, the read access window and the bus turnaround gap are whole clock counts. Each count is derived from nanosecond limits and a clock-period parameter, rounded up and never less than one. Output enable stays high for every write. The controller drives the shared data bus only through the write window plus one hold cycle. After a read it leaves the bus undriven for the turnaround count and at least one further cycle. Between requests both chip selects are inactive, which lets the memory drop into its deselected low-power state.

Top module: `async_sram_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset: ce1_n=1, ce2=0, we_n=1, oe_n=1, dq_oe=0, ready_o=1, done_o=0.
- R2: A write request stores wdata_i at addr_i. A later read of that address returns the same byte on rdata_o.
- R3: Each write produces exactly one we_n low pulse, lasting WE_CYC consecutive cycles (the larger of ceil(T_WE_NS/CLK_PERIOD_NS) and ceil(T_SD_NS/CLK_PERIOD_NS)). Both chip selects are active (ce1_n=0, ce2=1) throughout the pulse.
- R4: During every we_n low cycle, and in the one cycle after we_n rises, dq_oe=1 and dq_o equals the request's data. The address does not change while we_n is low.
- R5: oe_n is high in every cycle in which we_n is low.
- R6: A read holds ce1_n=0, ce2=1, we_n=1 and oe_n=0 for exactly ACC_CYC consecutive cycles (the larger of ceil(T_ACC_NS/CLK_PERIOD_NS) and ceil(T_DOE_NS/CLK_PERIOD_NS)). rdata_o takes the bus value sampled at the clock edge that ends that window.
- R7: dq_oe is never high while oe_n is low. After oe_n rises, dq_oe stays low for at least TURN_CYC+1 cycles, where TURN_CYC = ceil(T_OEHZ_NS/CLK_PERIOD_NS).
- R8: done_o is high for exactly one cycle per accepted request. ready_o is low from the cycle after acceptance until that pulse.
- R9: A request raised while ready_o is low is ignored. It produces no memory cycle and no done pulse.
- R10: Whenever ready_o is high, ce1_n=1 and ce2=0.
- R11: Measured from the cycle after acceptance, done_o rises in cycle WE_CYC+3 for a write and in cycle ACC_CYC+TURN_CYC+1 for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled while ready_o is high |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Captured read data |
| ready_o | output | 1 | Controller idle, request may be raised |
| done_o | output | 1 | One-cycle completion pulse |
| sram_ce1_n_o | output | 1 | Chip select, active low |
| sram_ce2_o | output | 1 | Chip select, active high |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_dq_o | output | DATA_W | Data driven toward memory |
| sram_dq_oe_o | output | 1 | Data driver enable |
| sram_dq_i | input | DATA_W | Data sampled from memory |

## Verification
The memory model returns a poison byte until the read window has run its full count. A controller that captured one edge early would therefore return that byte instead of the stored value. Chaining a write into the completion cycle of a read makes the turnaround gap as short as it can legally be. A controller that let go of the bus too early would then show up as driving while the memory model still drives. The model also commits data only at the end of the write window and compares the bytes seen in the hold cycle. This catches a controller that drops its drivers together with we_n, or that stretches or splits the pulse. A second request raised in the middle of a write has to leave memory and the count of completion pulses unchanged.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RTURN
  } phase_e;

  // ceil(ns/period), never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_TIMER_COUNTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

  AST_TIMER_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W    = 1,
  parameter int unsigned WE_CYC   = 1,
  parameter int unsigned ACC_CYC  = 1,
  parameter int unsigned TURN_CYC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic             tmr_expired_i,
  output phase_e           phase_q_o,
  output phase_e           phase_d_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] WE_LD   = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  phase_e phase_q, phase_d;
  logic   done_q, done_d;

  always_comb begin
    phase_d    = phase_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    done_d     = 1'b0;
    unique case (phase_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        if (wr_i) begin
          phase_d = ST_WSET;
        end else begin
          phase_d    = ST_RACC;
          tmr_load_o = 1'b1;
          tmr_val_o  = ACC_LD;
        end
      end
      ST_WSET: begin
        phase_d    = ST_WPULSE;
        tmr_load_o = 1'b1;
        tmr_val_o  = WE_LD;
      end
      ST_WPULSE: if (tmr_expired_i) phase_d = ST_WHOLD;
      ST_WHOLD: begin
        phase_d = ST_IDLE;
        done_d  = 1'b1;
      end
      ST_RACC: if (tmr_expired_i) begin
        phase_d    = ST_RTURN;
        capture_o  = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = TURN_LD;
      end
      ST_RTURN: if (tmr_expired_i) begin
        phase_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign phase_q_o = phase_q;
  assign phase_d_o = phase_d;
  assign done_o    = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_DONE_IN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (phase_q == ST_IDLE)); // R8

  AST_PULSE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_WPULSE) |=> (phase_q inside {ST_WPULSE, ST_WHOLD})); // R3

  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_WSET) |=> (phase_q == ST_WPULSE)); // R9

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_d_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              ce1_n_o,
  output logic              ce2_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic              dq_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic sel_d, oe_d, we_d, drv_d;

  always_comb begin
    sel_d = phase_d_i inside {ST_WSET, ST_WPULSE, ST_WHOLD, ST_RACC};
    oe_d  = (phase_d_i == ST_RACC);
    we_d  = (phase_d_i == ST_WPULSE);
    drv_d = phase_d_i inside {ST_WSET, ST_WPULSE, ST_WHOLD};
  end

  // pins registered from next phase so no decode glitch reaches the memory
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce1_n_o <= 1'b1;
      ce2_o   <= 1'b0;
      oe_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      ce1_n_o <= !sel_d;
      ce2_o   <= sel_d;
      oe_n_o  <= !oe_d;
      we_n_o  <= !we_d;
      dq_oe_o <= drv_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      dq_o    <= '0;
      rdata_o <= '0;
    end else begin
      if (accept_i) begin
        addr_o <= addr_i;
        dq_o   <= wdata_i;
      end
      if (capture_i) rdata_o <= dq_i;
    end
  end

  AST_WE_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> oe_n_o); // R5

  AST_WE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> (!ce1_n_o && ce2_o)); // R3

  AST_WE_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> dq_oe_o); // R4

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> (dq_oe_o && $stable(dq_o))); // R4

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> $stable(addr_o)); // R4

  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> !dq_oe_o); // R7

  AST_TURN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_n_o) |-> !dq_oe_o); // R7

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_WE_NS       = 7,
  parameter int unsigned T_SD_NS       = 6,
  parameter int unsigned T_ACC_NS      = 10,
  parameter int unsigned T_DOE_NS      = 5,
  parameter int unsigned T_OEHZ_NS     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              done_o,
  output logic              sram_ce1_n_o,
  output logic              sram_ce2_o,
  output logic              sram_oe_n_o,
  output logic              sram_we_n_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned WE_CYC   = max_u(ns_to_cyc(T_WE_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_SD_NS, CLK_PERIOD_NS));
  localparam int unsigned ACC_CYC  = max_u(ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_DOE_NS, CLK_PERIOD_NS));
  localparam int unsigned TURN_CYC = ns_to_cyc(T_OEHZ_NS, CLK_PERIOD_NS);
  localparam int unsigned CNT_MAX  = max_u(max_u(WE_CYC, ACC_CYC), TURN_CYC);
  localparam int unsigned CNT_W    = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

  phase_e           phase_q, phase_d;
  logic             tmr_load, tmr_expired, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  sram_seq_fsm #(
    .CNT_W    (CNT_W),
    .WE_CYC   (WE_CYC),
    .ACC_CYC  (ACC_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .wr_i          (wr_i),
    .tmr_expired_i (tmr_expired),
    .phase_q_o     (phase_q),
    .phase_d_o     (phase_d),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .accept_o      (accept),
    .capture_o     (capture),
    .done_o        (done_o)
  );

  sram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_d_i (phase_d),
    .accept_i  (accept),
    .capture_i (capture),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .dq_i      (sram_dq_i),
    .ce1_n_o   (sram_ce1_n_o),
    .ce2_o     (sram_ce2_o),
    .oe_n_o    (sram_oe_n_o),
    .we_n_o    (sram_we_n_o),
    .dq_oe_o   (sram_dq_oe_o),
    .addr_o    (sram_addr_o),
    .dq_o      (sram_dq_o),
    .rdata_o   (rdata_o)
  );

  assign ready_o = (phase_q == ST_IDLE);

  AST_IDLE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce1_n_o && !sram_ce2_o)); // R10

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_n_o || !sram_oe_n_o) |-> !ready_o); // R8

endmodule

// File: tb/sim_async_sram_ctrl.sv
module sim_async_sram_ctrl;

  localparam int CLK_NS = 10;
  localparam int WE_NS = 22, SD_NS = 6, ACC_NS = 15, DOE_NS = 5, HZ_NS = 12;
  localparam int WE_C   = (WE_NS + CLK_NS - 1) / CLK_NS;   // 3
  localparam int ACC_C  = (ACC_NS + CLK_NS - 1) / CLK_NS;  // 2
  localparam int TURN_C = (HZ_NS + CLK_NS - 1) / CLK_NS;   // 2
  localparam int WR_LAT = WE_C + 3;
  localparam int RD_LAT = ACC_C + TURN_C + 1;

  // {wr, addr, data}; for reads data is the expected byte
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 13'h0000, 8'hA5},
    {1'b1, 13'h1FFF, 8'h5A},
    {1'b1, 13'h0ABC, 8'h3C},
    {1'b0, 13'h0000, 8'hA5},
    {1'b1, 13'h1555, 8'hFF},
    {1'b0, 13'h1FFF, 8'h5A},
    {1'b1, 13'h0AAA, 8'h00},
    {1'b0, 13'h0ABC, 8'h3C},
    {1'b1, 13'h0000, 8'h81},
    {1'b0, 13'h1555, 8'hFF},
    {1'b0, 13'h0000, 8'h81},
    {1'b0, 13'h0AAA, 8'h00}
  };

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ready, done;
  logic        ce1_n, ce2, oe_n, we_n, dq_oe;
  logic [12:0] s_addr;
  logic [7:0]  s_dq_o;
  logic [7:0]  s_dq_i = 8'hEE;

  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  async_sram_ctrl #(
    .CLK_PERIOD_NS(CLK_NS), .T_WE_NS(WE_NS), .T_SD_NS(SD_NS),
    .T_ACC_NS(ACC_NS), .T_DOE_NS(DOE_NS), .T_OEHZ_NS(HZ_NS)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .done_o(done),
    .sram_ce1_n_o(ce1_n), .sram_ce2_o(ce2), .sram_oe_n_o(oe_n), .sram_we_n_o(we_n),
    .sram_addr_o(s_addr), .sram_dq_o(s_dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(s_dq_i)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req_tag, act, exp, $time);
    end
  endtask

  // memory model, sampled mid-cycle
  logic [7:0] mem [int];
  int  we_run = 0, rd_run = 0, gap = 0, writes_n = 0, dones_n = 0;
  bit  wr_pend = 0, gap_track = 0;
  logic [7:0]  wr_d_m;
  logic [12:0] wr_a_m;

  function automatic logic [7:0] peek(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(negedge clk) if (rst_ni) begin
    automatic bit wr_act = !ce1_n && ce2 && !we_n;
    automatic bit rd_act = !ce1_n && ce2 && !oe_n && we_n;
    if (done) dones_n++;
    if (ready && !(ce1_n && !ce2)) chk(0, "R10", {ce1_n, ce2}, 2'b10);
    if (!we_n && !oe_n) chk(0, "R5", oe_n, 1);
    if (!we_n && !(ce1_n == 1'b0 && ce2)) chk(0, "R3", {ce1_n, ce2}, 2'b01);
    if (wr_act) begin
      we_run++;
      if (!dq_oe) chk(0, "R4", dq_oe, 1);
      if (we_run > 1 && (s_dq_o != wr_d_m || s_addr != wr_a_m)) chk(0, "R4", s_addr, wr_a_m);
      wr_d_m = s_dq_o; wr_a_m = s_addr; wr_pend = 1;
    end else if (wr_pend) begin
      chk(we_run == WE_C, "R3", we_run, WE_C);
      chk(dq_oe && s_dq_o == wr_d_m, "R4", s_dq_o, wr_d_m);
      mem[int'(wr_a_m)] = wr_d_m;
      wr_pend = 0; we_run = 0; writes_n++;
    end
    if (dq_oe && !oe_n) chk(0, "R7", dq_oe, 0);
    if (gap_track) begin
      if (dq_oe) begin
        chk(gap >= TURN_C + 1, "R7", gap, TURN_C + 1);
        gap_track = 0;
      end else gap++;
    end
    if (rd_act) rd_run++;
    else if (rd_run != 0) begin
      chk(rd_run == ACC_C, "R6", rd_run, ACC_C);
      rd_run = 0; gap_track = 1; gap = 1;
    end
    s_dq_i <= (rd_act && rd_run >= ACC_C) ? peek(int'(s_addr)) : 8'hEE;
  end

  task automatic do_op(input logic w, input logic [12:0] a, input logic [7:0] d,
                       output logic [7:0] rd, output int lat);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    chk(!ready, "R8", ready, 0);
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    rd = rdata;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    int lat, w0, d0;
    repeat (3) @(negedge clk);
    chk({ce1_n, ce2, we_n, oe_n, dq_oe} == 5'b10110, "R1", {ce1_n, ce2, we_n, oe_n, dq_oe}, 5'b10110);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({ce1_n, ce2, we_n, oe_n, dq_oe} == 5'b10110, "R1", {ce1_n, ce2, we_n, oe_n, dq_oe}, 5'b10110);
    chk(ready && !done, "R1", {ready, done}, 2'b10);
    chk(ce1_n && !ce2, "R10", {ce1_n, ce2}, 2'b10);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][21], VEC[i][20:8], VEC[i][7:0], rd, lat);
      if (VEC[i][21]) chk(lat == WR_LAT, "R11", lat, WR_LAT);
      else begin
        chk(lat == RD_LAT, "R11", lat, RD_LAT);
        chk(rd == VEC[i][7:0], "R2", rd, VEC[i][7:0]);
        chk(rd == VEC[i][7:0], "R6", rd, VEC[i][7:0]);
      end
      @(negedge clk);
      chk(!done && ready, "R8", {done, ready}, 2'b01);
    end

    // read chained straight into a write: tightest turnaround
    do_op(1'b0, 13'h1FFF, 8'h00, rd, lat);
    chk(rd == 8'h5A, "R6", rd, 8'h5A);
    do_op(1'b1, 13'h0F0F, 8'hC3, rd, lat);
    chk(lat == WR_LAT, "R7", lat, WR_LAT);
    @(negedge clk);
    do_op(1'b0, 13'h0F0F, 8'h00, rd, lat);
    chk(rd == 8'hC3, "R2", rd, 8'hC3);
    @(negedge clk);

    // request during busy is ignored
    w0 = writes_n; d0 = dones_n;
    req = 1'b1; wr = 1'b1; addr = 13'h0123; wdata = 8'h11;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = 13'h0456; wdata = 8'h99;
    @(negedge clk);
    req = 1'b0;
    lat = 0;
    while (!done && lat < 60) begin @(negedge clk); lat++; end
    repeat (WR_LAT + 2) @(negedge clk);
    chk(writes_n == w0 + 1, "R9", writes_n - w0, 1);
    chk(dones_n == d0 + 1, "R9", dones_n - d0, 1);
    do_op(1'b0, 13'h0456, 8'h00, rd, lat);
    chk(rd == 8'h00, "R9", rd, 8'h00);
    @(negedge clk);
    do_op(1'b0, 13'h0123, 8'h00, rd, lat);
    chk(rd == 8'h11, "R2", rd, 8'h11);
    @(negedge clk);
    chk(ce1_n && !ce2 && oe_n && we_n && !dq_oe, "R10", {ce1_n, ce2, oe_n, we_n, dq_oe}, 5'b10110);

    finish_run();
  end

endmodule